// File: doc/BRIEF.md
# Flash Busy-Status Read Multiplexer

This block sits in the read path of a byte-wide parallel flash device model. It decodes the chip-select, output-enable and write-enable controls into an operating mode, and it decides what byte appears on the data pins during a read. When no internal operation is running, a read returns the array byte. While a program, an erase or the sector-erase time-out window is active, the top data bit carries a polling status bit instead. The host can poll that bit to learn whether the internal algorithm has finished.

A small state machine samples the externally supplied operation state on each rising clock edge. Its states are IDLE, PROG_BUSY, ERASE_BUSY, ERASE_WAIT (the time-out window), PROG_SETTLE and ERASE_SETTLE. Its transitions are:
- GO_PROG: any state moves to PROG_BUSY when the operation state is 01.
- GO_ERASE: any state moves to ERASE_BUSY when the operation state is 10.
- GO_WAIT: any state moves to ERASE_WAIT when the operation state is 11.
- END_PROG: PROG_BUSY moves to PROG_SETTLE when the operation state is 00.
- END_ERASE: ERASE_BUSY or ERASE_WAIT moves to ERASE_SETTLE when the operation state is 00.
- SETTLED: a settle state moves to IDLE when a read is active at the edge.
- HOLD: in every other case the state machine keeps its state.

While the state machine reports status, and in the first read after an operation ends, the lower bits come from a holding value that is modelled as zero. A host must not trust those bits.

Top module: `flash_poll_rdmux`

## Requirements
- R1: A read is active when cs_n=0, oe_n=0 and we_n=1. During a read, dq_oe is 1. With no operation pending (IDLE), dq_out equals array_rd.
- R2: When cs_n=1 (standby), dq_oe is 0 and dq_out is all zeros, whatever the other inputs are.
- R3: When cs_n=0 and either oe_n=1 (outputs disabled) or we_n=0 (write), dq_oe is 0 and dq_out is all zeros.
- R4: While programming (op_state=01 sampled at the previous rising edge), a read returns the inverse of wr_msb on bit DW-1.
- R5: After a program ends (op_state back to 00), reads return wr_msb on bit DW-1 and zeros on the lower bits. This lasts until a read is active at a rising edge. After that edge, reads return array_rd.
- R6: While erasing (op_state=10) or in the time-out window (op_state=11), a read with erase_hit=1 returns 0 on bit DW-1.
- R7: While erasing or in the time-out window, a read with erase_hit=0 returns array_rd unchanged.
- R8: Whenever status is substituted on bit DW-1, bits DW-2..0 of dq_out are 0.
- R9: The operation state takes effect one clock cycle after it is sampled: a change of op_state does not alter dq_out before the next rising edge.
- R10: After reset, the state machine is IDLE and a read returns array_rd.
- R11: After an erase ends, a read with erase_hit=1 returns array_rd bit DW-1 on bit DW-1 and zeros below it, until a read is active at a rising edge. A read with erase_hit=0 returns array_rd.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| op_state | input | 2 | Internal operation: 00 none, 01 program, 10 erase, 11 sector-erase time-out |
| erase_hit | input | 1 | Read address lies in a sector being erased |
| wr_msb | input | 1 | Top bit of the byte last written |
| array_rd | input | DW | Array read data |
| dq_out | output | DW | Data bus value (zero when not driven) |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
The bench builds the block with DW=8, so the status bit is bit 7. The lower seven bits form the holding field that must read as zero during status. Directed sequences cover every state and transition, including the following:
- long settle periods with no reads;
- a new operation starting before a settle read;
- erase reads with erase_hit both set and clear.

A pseudo-random phase then mixes the control pins, the operation codes and the data against the behavioural model on every cycle.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_WAIT  = 2'd3
    } op_code_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG_BUSY,
        ST_ERASE_BUSY,
        ST_ERASE_WAIT,
        ST_PROG_SETTLE,
        ST_ERASE_SETTLE
    } poll_state_e;

    typedef enum logic [1:0] {
        MD_STANDBY,
        MD_DISABLE,
        MD_WRITE,
        MD_READ
    } pin_mode_e;

endpackage

// File: rtl/flash_mode_dec.sv
module flash_mode_dec
    import flash_rd_pkg::*;
(
    input  logic      cs_n,
    input  logic      oe_n,
    input  logic      we_n,
    output pin_mode_e mode
);

    always_comb begin
        if (cs_n)
            mode = MD_STANDBY;
        else if (!we_n)
            mode = MD_WRITE;
        else if (oe_n)
            mode = MD_DISABLE;
        else
            mode = MD_READ;
    end

endmodule

// File: rtl/flash_poll_fsm.sv
module flash_poll_fsm
    import flash_rd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  op_state,
    input  logic        rd_act,
    output poll_state_e state_q
);

    poll_state_e state_d;
    op_code_e    op;

    assign op = op_code_e'(op_state);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (op)
            OP_PROG:  state_d = ST_PROG_BUSY;
            OP_ERASE: state_d = ST_ERASE_BUSY;
            OP_WAIT:  state_d = ST_ERASE_WAIT;
            OP_NONE: begin
                unique case (state_q)
                    ST_PROG_BUSY:    state_d = ST_PROG_SETTLE;
                    ST_ERASE_BUSY,
                    ST_ERASE_WAIT:   state_d = ST_ERASE_SETTLE;
                    ST_PROG_SETTLE,
                    ST_ERASE_SETTLE: state_d = rd_act ? ST_IDLE : state_q;
                    default:         state_d = ST_IDLE;
                endcase
            end
            default: state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/flash_rd_sel.sv
module flash_rd_sel
    import flash_rd_pkg::*;
#(
    parameter int DW = 8
) (
    input  poll_state_e   state_q,
    input  logic          erase_hit,
    input  logic          wr_msb,
    input  logic [DW-1:0] array_rd,
    output logic [DW-1:0] rd_byte
);

    localparam int MSB = DW - 1;
    localparam logic [DW-2:0] HOLD_BITS = '0;

    always_comb begin
        unique case (state_q)
            ST_IDLE:         rd_byte = array_rd;
            ST_PROG_BUSY:    rd_byte = {~wr_msb, HOLD_BITS};
            ST_ERASE_BUSY,
            ST_ERASE_WAIT:   rd_byte = erase_hit ? {1'b0, HOLD_BITS} : array_rd;
            ST_PROG_SETTLE:  rd_byte = {wr_msb, HOLD_BITS};
            ST_ERASE_SETTLE: rd_byte = erase_hit ? {array_rd[MSB], HOLD_BITS} : array_rd;
            default:         rd_byte = array_rd;
        endcase
    end

endmodule

// File: rtl/flash_poll_rdmux.sv
module flash_poll_rdmux
    import flash_rd_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [1:0]    op_state,
    input  logic          erase_hit,
    input  logic          wr_msb,
    input  logic [DW-1:0] array_rd,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe
);

    pin_mode_e     mode;
    poll_state_e   state_q;
    logic          rd_act;
    logic [DW-1:0] rd_byte;

    flash_mode_dec u_mode (
        .cs_n (cs_n),
        .oe_n (oe_n),
        .we_n (we_n),
        .mode (mode)
    );

    assign rd_act = (mode == MD_READ);

    flash_poll_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_state (op_state),
        .rd_act   (rd_act),
        .state_q  (state_q)
    );

    flash_rd_sel #(.DW(DW)) u_sel (
        .state_q   (state_q),
        .erase_hit (erase_hit),
        .wr_msb    (wr_msb),
        .array_rd  (array_rd),
        .rd_byte   (rd_byte)
    );

    always_comb begin
        unique case (mode)
            MD_READ: begin
                dq_oe  = 1'b1;
                dq_out = rd_byte;
            end
            MD_STANDBY, MD_DISABLE, MD_WRITE: begin
                dq_oe  = 1'b0;
                dq_out = '0;
            end
            default: begin
                dq_oe  = 1'b0;
                dq_out = '0;
            end
        endcase
    end

endmodule

// File: rtl/flash_poll_rdmux_chk.sv
module flash_poll_rdmux_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          oe_n,
    input logic          we_n,
    input logic [1:0]    op_state,
    input logic          erase_hit,
    input logic          wr_msb,
    input logic [DW-1:0] dq_out,
    input logic          dq_oe
);

    p_standby_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!dq_oe && dq_out == '0));

    p_disable_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && (oe_n || !we_n)) |-> !dq_oe);

    p_prog_inv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_state) == 2'd1 && dq_oe) |-> (dq_out[DW-1] == !wr_msb));

    p_erase_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_state[1]) && erase_hit && dq_oe) |-> !dq_out[DW-1]);

    p_hold_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_state) == 2'd1 && dq_oe) |-> (dq_out[DW-2:0] == '0));

endmodule

bind flash_poll_rdmux flash_poll_rdmux_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .op_state  (op_state),
    .erase_hit (erase_hit),
    .wr_msb    (wr_msb),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe)
);

// File: tb/flash_poll_rdmux_bench.sv
module flash_poll_rdmux_bench;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [1:0]    op_state = 2'd0;
    logic          erase_hit = 1'b0;
    logic          wr_msb = 1'b0;
    logic [DW-1:0] array_rd = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;

    int errors = 0;
    int checks = 0;
    int ms = 0;  // model: 0 none,1 prog,2 erase,3 wait,4 prog settle,5 erase settle
    bit done = 0;

    always #10 clk = ~clk;

    flash_poll_rdmux #(.DW(DW)) u_flash_poll_rdmux (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
        .op_state(op_state), .erase_hit(erase_hit), .wr_msb(wr_msb),
        .array_rd(array_rd), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    function automatic bit reading();
        return (cs_n == 1'b0) && (oe_n == 1'b0) && (we_n == 1'b1);
    endfunction

    function automatic logic [DW-1:0] model_byte();
        logic [DW-1:0] v;
        if (!reading()) return '0;
        v = array_rd;
        if (ms == 1) v = {!wr_msb, 7'd0};
        else if ((ms == 2 || ms == 3) && erase_hit) v = 8'd0;
        else if (ms == 4) v = {wr_msb, 7'd0};
        else if (ms == 5 && erase_hit) v = {array_rd[7], 7'd0};
        return v;
    endfunction

    function automatic string model_tag();
        if (cs_n) return "R2";
        if (!reading()) return "R3";
        case (ms)
            0: return "R1";
            1: return "R4";
            2, 3: return erase_hit ? "R6" : "R7";
            4: return "R5";
            default: return "R11";
        endcase
    endfunction

    task automatic check(string tag, logic [DW:0] act, logic [DW:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic step(string tag = "");
        string t;
        logic [DW-1:0] e;
        bit rd;
        #5;
        t = (tag != "") ? tag : model_tag();
        e = model_byte();
        check(t, {dq_oe, dq_out}, {reading(), e});
        if (reading() && (ms == 1 || ((ms == 2 || ms == 3) && erase_hit)))
            check("R8", {1'b0, dq_out[6:0]}, 9'd0);
        rd = reading();
        @(posedge clk);
        if (op_state == 2'd1) ms = 1;
        else if (op_state == 2'd2) ms = 2;
        else if (op_state == 2'd3) ms = 3;
        else if (ms == 1) ms = 4;
        else if (ms == 2 || ms == 3) ms = 5;
        else if ((ms == 4 || ms == 5) && rd) ms = 0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [DW-1:0] a);
        cs_n = 0; oe_n = 0; we_n = 1; array_rd = a;
    endtask

    task automatic idle_pins();
        cs_n = 0; oe_n = 1; we_n = 1;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state, read returns array
        rd(8'hA5);
        step("R10");
        // R1: plain reads with several patterns
        rd(8'h3C); step();
        rd(8'hFF); step();
        rd(8'h00); step();
        // R2: standby
        cs_n = 1; oe_n = 0; we_n = 1; array_rd = 8'h81; step();
        // R3: output disabled and write
        idle_pins(); step();
        cs_n = 0; oe_n = 0; we_n = 0; step();
        cs_n = 0; oe_n = 1; we_n = 0; step();
        // R9: op change not visible before edge
        rd(8'h5A); wr_msb = 1; op_state = 2'd1; step("R9");
        // R4: programming, both polarities of wr_msb
        step(); wr_msb = 0; step(); rd(8'hFF); step();
        idle_pins(); step();
        // R5: program ends, settle persists without reads
        wr_msb = 1; op_state = 2'd0; rd(8'h12); step();
        idle_pins(); step(); step();
        rd(8'h34); step("R5");
        rd(8'h34); step("R5");
        // R6/R7: erase hit / miss, time-out window
        op_state = 2'd2; rd(8'hF0); step();
        erase_hit = 1; step(); step();
        erase_hit = 0; step();
        op_state = 2'd3; erase_hit = 1; step(); step();
        erase_hit = 0; rd(8'h9E); step();
        // R11: erase settle
        op_state = 2'd0; erase_hit = 1; rd(8'hC3); step();
        rd(8'h43); step("R11");
        erase_hit = 1; rd(8'hC3); step("R11");
        // new operation before settle read
        op_state = 2'd1; wr_msb = 0; step();
        op_state = 2'd0; idle_pins(); step(); step();
        op_state = 2'd2; erase_hit = 1; rd(8'h77); step();
        op_state = 2'd0; step(); step();
        // pseudo-random mix
        begin
            int unsigned lfsr = 32'h1ACE_B00C;
            for (int i = 0; i < 3000; i++) begin
                lfsr = lfsr * 1664525 + 1013904223;
                cs_n = lfsr[3] & lfsr[4];
                oe_n = lfsr[5] & lfsr[6];
                we_n = !(lfsr[7] & lfsr[8] & lfsr[9]);
                op_state = (lfsr[12:10] < 3'd4) ? 2'd0 : lfsr[14:13];
                erase_hit = lfsr[15];
                wr_msb = lfsr[16];
                array_rd = lfsr[31:24];
                step();
            end
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule